// File: doc/BRIEF.md
# Programmable Pattern Carrier Generator

This block turns a stored bit pattern into a continuous serial carrier. Software builds the pattern by writing 16-bit words into a pattern store of up to 1024 bits. Every write pushes the existing contents up by one word and puts the new word in the lowest bits. A length field selects how many of the lowest stored bits form the repeating pattern. A divider field sets how many system clock cycles each pattern bit lasts.

While the enable input is high, the block plays the selected bits from the top of the pattern down to bit 0 and then starts again at the top. It drives a true output and a complementary output. While the enable is low, the true output rests low and the complementary output rests high. Each rising enable restarts playback at the top of the pattern.

Top module: `pattern_carrier`

## Requirements
- R1: After reset, and from the first clock edge that samples `enable` low, `carrierP` is 0 and `carrierN` is 1.
- R2: `carrierN` is always the logical inverse of `carrierP`.
- R3: A clock edge with `wordValid` high moves the stored pattern up by 16 bits and places `wordData` in stored bits 15..0. Stored bit 15 of that word is its most significant bit. A word written earlier therefore sits at higher stored bit positions.
- R4: Playback runs from stored bit `lenMinus1` down to stored bit 0. The next bit period after bit 0 plays bit `lenMinus1` again, with no gap.
- R5: Each pattern bit lasts exactly `divider` clock cycles. A `divider` of 0 behaves like a `divider` of 1.
- R6: When a clock edge samples `enable` high after it was low, `carrierP` shows stored bit `lenMinus1` from that edge on.
- R7: `lenMinus1` holds the pattern length minus one. Both extremes are supported: a value of 0 repeats a single bit, and a value of 1023 plays all 1024 stored bits.
- R8: A pattern word written while `enable` is low does not change the resting outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wordValid | input | 1 | Pattern word write strobe |
| wordData | input | 16 | Pattern word; bit 15 is played first |
| lenMinus1 | input | 10 | Pattern length minus one (0..1023) |
| divider | input | 16 | Clock cycles per pattern bit; 0 acts as 1 |
| enable | input | 1 | Runs playback while high |
| carrierP | output | 1 | True carrier output |
| carrierN | output | 1 | Complementary carrier output |

## Verification
Several patterns are used, and each one separates a different fault. A single asymmetric word played at divider 1 shows bit order and wraparound. A 5-bit pattern at divider 3 shows bit hold time and a wrap that does not fall on a word boundary. A three-word pattern at divider 2 shows whether earlier words land at higher positions. A divider of 0 and a one-bit pattern cover the low extremes. A full 1024-bit pattern that wraps covers the top of the index range. Each run stops part way through the pattern, so the next rising enable shows whether playback restarts at the top and not where it left off.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic start;   // playback begins this edge
    logic step;    // advance to next pattern bit this edge
    logic active;  // playback currently running
  } seqStrobes_t;
endpackage

// File: rtl/pcg_pattern_store.sv
module pcg_pattern_store #(
  parameter int MAX_BITS = 1024,
  parameter int WORD_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wordValid,
  input  logic [WORD_W-1:0]   wordData,
  output logic [MAX_BITS-1:0] patBits
);
  localparam int NUM_WORDS = MAX_BITS / WORD_W;

  // One register per word slot; each write moves every slot up one place.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    logic [WORD_W-1:0] wordQ;
    logic [WORD_W-1:0] wordNext;
    if (w == 0) begin : gBottom
      assign wordNext = wordData;
    end else begin : gUpper
      assign wordNext = patBits[(w-1)*WORD_W +: WORD_W];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wordQ <= '0;
      else if (wordValid) wordQ <= wordNext;
    end
    assign patBits[w*WORD_W +: WORD_W] = wordQ;
  end
endmodule

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
  import pcg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divider,
  output seqStrobes_t      strobes
);
  logic             running;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;

  // Zero divider behaves as one; last count of a bit period
  always_comb begin
    divLast = (divider == '0) ? '0 : divider - 1'b1;
  end

  always_comb begin
    strobes.start  = enable & ~running;
    strobes.step   = enable & running & (divCnt >= divLast);
    strobes.active = running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      divCnt  <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      divCnt  <= '0;
    end else if (!running) begin
      running <= 1'b1;
      divCnt  <= '0;
    end else if (strobes.step) begin
      divCnt  <= '0;
    end else begin
      divCnt  <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pcg_datapath.sv
module pcg_datapath
  import pcg_pkg::*;
#(
  parameter int MAX_BITS = 1024,
  parameter int LEN_W    = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strobes,
  input  logic [LEN_W-1:0]    lenMinus1,
  input  logic [MAX_BITS-1:0] patBits,
  output logic [LEN_W-1:0]    bitIdx,
  output logic                carrierP,
  output logic                carrierN
);
  logic patBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx <= '0;
    end else if (strobes.start) begin
      bitIdx <= lenMinus1;
    end else if (strobes.step) begin
      bitIdx <= (bitIdx == '0) ? lenMinus1 : bitIdx - 1'b1;
    end
  end

  always_comb begin
    patBit   = patBits[bitIdx];
    carrierP = strobes.active & patBit;
    carrierN = ~strobes.active | ~patBit;
  end
endmodule

// File: rtl/pattern_carrier.sv
module pattern_carrier
  import pcg_pkg::*;
#(
  parameter int MAX_BITS = 1024,
  parameter int WORD_W   = 16,
  parameter int DIV_W    = 16,
  parameter int LEN_W    = $clog2(MAX_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  input  logic [LEN_W-1:0]  lenMinus1,
  input  logic [DIV_W-1:0]  divider,
  input  logic              enable,
  output logic              carrierP,
  output logic              carrierN
);
  seqStrobes_t         strobes;
  logic [MAX_BITS-1:0] patBits;
  logic [LEN_W-1:0]    bitIdx;

  pcg_pattern_store #(.MAX_BITS(MAX_BITS), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .patBits(patBits)
  );

  pcg_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .divider(divider),
    .strobes(strobes)
  );

  pcg_datapath #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lenMinus1(lenMinus1),
    .patBits(patBits), .bitIdx(bitIdx), .carrierP(carrierP), .carrierN(carrierN)
  );
endmodule

// File: rtl/pattern_carrier_chk.sv
module pattern_carrier_chk #(
  parameter int MAX_BITS = 1024,
  parameter int WORD_W   = 16,
  parameter int LEN_W    = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                wordValid,
  input logic [WORD_W-1:0]   wordData,
  input logic [LEN_W-1:0]    lenMinus1,
  input logic                enable,
  input logic                carrierP,
  input logic                carrierN,
  input logic                start,
  input logic                step,
  input logic                active,
  input logic [LEN_W-1:0]    bitIdx,
  input logic [MAX_BITS-1:0] patBits
);
  assert_resting_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (!carrierP && carrierN));

  assert_complement_R2: assert property (@(posedge clk) disable iff (!rstN)
    carrierN == !carrierP);

  assert_word_lsb_R3: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> patBits[WORD_W-1:0] == $past(wordData));

  assert_word_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> patBits[2*WORD_W-1:WORD_W] == $past(patBits[WORD_W-1:0]));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (step && bitIdx == '0) |=> bitIdx == $past(lenMinus1));

  assert_descend_R4: assert property (@(posedge clk) disable iff (!rstN)
    (step && bitIdx != '0) |=> bitIdx == $past(bitIdx) - 1'b1);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (active && !step) |=> $stable(bitIdx));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (bitIdx == $past(lenMinus1) && active));
endmodule

bind pattern_carrier pattern_carrier_chk #(
  .MAX_BITS(MAX_BITS), .WORD_W(WORD_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
  .lenMinus1(lenMinus1), .enable(enable), .carrierP(carrierP),
  .carrierN(carrierN), .start(strobes.start), .step(strobes.step),
  .active(strobes.active), .bitIdx(bitIdx), .patBits(patBits)
);

// File: tb/tb_pattern_carrier.sv
module tb_pattern_carrier;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic [9:0]  lenMinus1 = '0;
  logic [15:0] divider = 16'd1;
  logic        enable = 1'b0;
  logic        carrierP;
  logic        carrierN;

  int errors = 0;
  int checks = 0;
  logic [1023:0] model = '0;
  bit    expQ[$];
  string tagQ[$];
  bit    finished = 0;

  always #2.5 clk = ~clk;

  pattern_carrier dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .lenMinus1(lenMinus1), .divider(divider), .enable(enable),
    .carrierP(carrierP), .carrierN(carrierN)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected value per cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        bit    e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, carrierP, e);
        check("R2", carrierN, ~e);
      end
    end
  end

  // R3 R8: write one word while disabled; outputs must stay at rest
  task automatic writeWord(input logic [15:0] w);
    @(negedge clk);
    wordValid = 1'b1;
    wordData  = w;
    model     = {model[1007:0], w};
    @(negedge clk);
    wordValid = 1'b0;
    check("R8", carrierP, 1'b0);
    check("R8", carrierN, 1'b1);
  endtask

  // Driver: plays the pattern for a number of cycles, then disables
  task automatic runCase(input int lenM1, input int div, input int cycles, input string tag);
    int divEff;
    divEff = (div == 0) ? 1 : div;
    @(negedge clk);
    lenMinus1 = lenM1[9:0];
    divider   = div[15:0];
    enable    = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      int period;
      int idx;
      period = c / divEff;
      idx = lenM1 - (period % (lenM1 + 1));
      expQ.push_back(model[idx]);
      tagQ.push_back((c == 0) ? "R6" : tag);
    end
    wait (expQ.size() == 0);
    @(negedge clk);
    enable = 1'b0;
    expQ.push_back(1'b0);
    tagQ.push_back("R1");
    wait (expQ.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", carrierP, 1'b0);
    check("R1", carrierN, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", carrierP, 1'b0);
    check("R2", carrierN, 1'b1);

    // Single asymmetric word, divider 1, wraps twice and stops mid-pattern
    writeWord(16'hA5C3);
    runCase(15, 1, 41, "R4");
    // Restart from top after partial run; 5-bit pattern, divider 3
    runCase(4, 3, 40, "R5");
    // Three words: earlier words at higher positions (R3), divider 2
    writeWord(16'h8001);
    writeWord(16'h0FF0);
    writeWord(16'h3C5A);
    runCase(39, 2, 170, "R3");
    // Divider zero acts as one
    runCase(11, 0, 30, "R5");
    // One-bit pattern (R7)
    runCase(0, 2, 12, "R7");
    runCase(2, 1, 10, "R4");
    // Full 1024-bit pattern (R7)
    for (int i = 0; i < 64; i++) writeWord(16'(i * 40503) ^ 16'h5A5A);
    runCase(1023, 1, 1100, "R7");
    runCase(1023, 2, 60, "R6");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule